// File: doc/BRIEF.md
# Tagged TLB Lookup and Probe

This block is a small, fully associative translation buffer for a paged memory unit. Every entry holds a double-page virtual tag (VPN2), a page-size mask, a short address-space identifier, a wide memory-map identifier, a global flag, an invalidate hint, and a valid, dirty, read-inhibit and execute-inhibit bit plus a frame field for each of its even and odd pages. The block keeps the working registers that software loads before an operation: an entry-high word, two entry-low words, a page-mask word, an index word and a map-ID word.

One configuration input picks the tag used to tell address spaces apart. When it is clear, the short identifier in the entry-high word is compared, narrowed to 8 or 10 bits by a second configuration input. When it is set, the 32-bit map-ID register is compared, and the short identifier is forced to zero wherever it is captured. A combinational lookup port translates any virtual address. Three strobes drive a probe for the first matching entry, an indexed write of the working registers into an entry, and an indexed read of an entry back into them.

Top module: `tlb_tagged_lookup`

## Requirements
- R1: After reset all six working registers read 0 and every entry is invalidated: no lookup hits and a probe misses.
- R2: The current tag is the map-ID register when `cfg_mmid_en` is 1. Otherwise it is the entry-high identifier (bits 9:0) under the identifier mask, zero-extended to 32 bits. Each entry's tag is its stored map ID or its zero-extended stored identifier, selected by the same input.
- R3: An entry matches only when its invalidate hint is 0, and its global flag is 1 or its tag equals the current tag, and its VPN2 equals the compared VPN2 on every bit its page mask does not cover.
- R4: The identifier mask is 0 when `cfg_mmid_en` is 1, 0x3FF when `cfg_asid_ext` is 1, and 0xFF otherwise. It is applied when an entry is written and when the current tag is formed.
- R5: `cmd_write` stores into the selected entry: VPN2 (entry-high 31:13), the invalidate hint (entry-high bit 10), the masked identifier, the map-ID register, page-mask bits 28:13, and entry-low bits 31:1 of both words. The global flag is the AND of bit 0 of the two entry-low words.
- R6: Write and read select entry (index register bits 30:0) modulo ENTRIES, so bit 31 is ignored.
- R7: `cmd_read` of a valid entry loads entry-high with VPN2 in bits 31:13 and, only when `cfg_mmid_en` is 0, the stored identifier in bits 9:0. It loads the map-ID register with the stored map ID, page-mask with the mask in bits 28:13, and each entry-low with the stored bits 31:1 and the global flag in bit 0.
- R8: `cmd_read` of an entry whose invalidate hint is set loads entry-high with 0x400, zeroes page-mask and both entry-low words, and leaves the map-ID register unchanged.
- R9: `cmd_probe` compares entry-high VPN2 under the current tag and writes the lowest matching entry number into the index register.
- R10: A probe with no matching entry writes 0x8000_0000 into the index register.
- R11: The lookup reports a hit, the lowest matching entry number, and the selected page's valid (low bit 1), dirty (bit 2), frame (bits 29:3), execute-inhibit (bit 30) and read-inhibit (bit 31) bits. All of these are 0 on a miss.
- R12: The odd-page select is virtual-address bit 12+n, where n is the number of mask bits set (masks are contiguous from bit 13). The odd page is chosen when that bit is 1.
- R13: With `reg_wr_en`, `reg_sel` picks the register loaded from `reg_wdata`: 0 entry-high, 1 entry-low 0, 2 entry-low 1, 3 page-mask (only bits 28:13 kept), 4 index, 5 map ID. When strobes coincide, read wins over probe, probe over write, and write over a register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mmid_en | input | 1 | Compare the wide map ID instead of the short identifier |
| cfg_asid_ext | input | 1 | Short identifier is 10 bits instead of 8 |
| reg_wr_en | input | 1 | Load one working register |
| reg_sel | input | 3 | Register select for the load |
| reg_wdata | input | 32 | Load data |
| cmd_probe | input | 1 | Probe strobe |
| cmd_write | input | 1 | Indexed write strobe |
| cmd_read | input | 1 | Indexed read strobe |
| lookup_va | input | 32 | Virtual address to translate |
| lookup_hit | output | 1 | Lookup matched an entry |
| lookup_idx | output | $clog2(ENTRIES) | Matching entry number |
| lookup_odd | output | 1 | Odd page of the pair selected |
| lookup_v | output | 1 | Selected page valid |
| lookup_d | output | 1 | Selected page dirty |
| lookup_ri | output | 1 | Selected page read-inhibit |
| lookup_xi | output | 1 | Selected page execute-inhibit |
| lookup_frame | output | 27 | Selected page frame field |
| reg_entryhi | output | 32 | Entry-high register |
| reg_entrylo0 | output | 32 | Entry-low register, even page |
| reg_entrylo1 | output | 32 | Entry-low register, odd page |
| reg_pagemask | output | 32 | Page-mask register |
| reg_index | output | 32 | Index register |
| reg_mmid | output | 32 | Map-ID register |

## Verification
A corrupted stored field shows up at the lookup port in the same cycle the address is applied, because translation is purely combinational. It also shows up on the register outputs one cycle after a read strobe. A wrong tag choice or identifier mask turns into a hit on the wrong entry or a miss for a whole address space. So lookups and probes are swept over every stored tag, a foreign tag, both identifier widths and both tag modes, across a VPN2 window wider than all entries. Overlapping entries with wide masks and a global entry expose ordering faults as a wrong entry number. Reads in both modes expose faults in field packing, in the global AND and in the invalidated-entry form.

// File: rtl/tlb_tagged_lookup.sv
module tlb_tagged_lookup #(
  parameter int ENTRIES = 8,
  parameter int MMID_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_mmid_en,
  input  logic                       cfg_asid_ext,
  input  logic                       reg_wr_en,
  input  logic [2:0]                 reg_sel,
  input  logic [31:0]                reg_wdata,
  input  logic                       cmd_probe,
  input  logic                       cmd_write,
  input  logic                       cmd_read,
  input  logic [31:0]                lookup_va,
  output logic                       lookup_hit,
  output logic [$clog2(ENTRIES)-1:0] lookup_idx,
  output logic                       lookup_odd,
  output logic                       lookup_v,
  output logic                       lookup_d,
  output logic                       lookup_ri,
  output logic                       lookup_xi,
  output logic [26:0]                lookup_frame,
  output logic [31:0]                reg_entryhi,
  output logic [31:0]                reg_entrylo0,
  output logic [31:0]                reg_entrylo1,
  output logic [31:0]                reg_pagemask,
  output logic [31:0]                reg_index,
  output logic [31:0]                reg_mmid
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int VPN_W  = 19;
  localparam int PM_W   = 16;
  localparam int ID_W   = 10;
  localparam int PG_W   = 31;
  localparam logic [31:0] MISS_WORD = 32'h8000_0000;
  localparam logic [31:0] INV_HI    = 32'h0000_0400;

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [PM_W-1:0]   e_pm   [ENTRIES];
  logic [ID_W-1:0]   e_asid [ENTRIES];
  logic [MMID_W-1:0] e_mmid [ENTRIES];
  logic [PG_W-1:0]   e_pg0  [ENTRIES];
  logic [PG_W-1:0]   e_pg1  [ENTRIES];
  logic [ENTRIES-1:0] e_g, e_inv;

  logic [ID_W-1:0]   asid_mask;
  logic [MMID_W-1:0] cur_tag;
  logic [IDX_W-1:0]  sel_idx, lk_idx, pr_idx;
  logic [ENTRIES-1:0] hit_lk, hit_pr;

  assign asid_mask = cfg_mmid_en ? '0 : (cfg_asid_ext ? 10'h3FF : 10'h0FF);
  assign cur_tag   = cfg_mmid_en ? reg_mmid[MMID_W-1:0]
                                 : MMID_W'(reg_entryhi[ID_W-1:0] & asid_mask);
  assign sel_idx   = IDX_W'(reg_index[30:0] % 31'(ENTRIES));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [MMID_W-1:0] e_tag;
    logic [VPN_W-1:0]  care;
    logic              tag_ok;
    assign e_tag  = cfg_mmid_en ? e_mmid[i] : MMID_W'(e_asid[i]);
    assign care   = ~{{(VPN_W-PM_W){1'b0}}, e_pm[i]};
    assign tag_ok = ~e_inv[i] & (e_g[i] | (e_tag == cur_tag));
    assign hit_lk[i] = tag_ok & (((e_vpn[i] ^ lookup_va[31:13]) & care) == '0);
    assign hit_pr[i] = tag_ok & (((e_vpn[i] ^ reg_entryhi[31:13]) & care) == '0);
  end

  always_comb begin
    lk_idx = '0;
    pr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_lk[i]) lk_idx = IDX_W'(i);
      if (hit_pr[i]) pr_idx = IDX_W'(i);
    end
  end

  logic [31:0]     span;
  logic [PG_W-1:0] pg;

  assign lookup_hit   = |hit_lk;
  assign lookup_idx   = lk_idx;
  assign span         = {3'b0, e_pm[lk_idx], 13'h1FFF};
  assign lookup_odd   = lookup_hit & (|(lookup_va & span & ~(span >> 1)));
  assign pg           = !lookup_hit ? '0 : (lookup_odd ? e_pg1[lk_idx] : e_pg0[lk_idx]);
  assign lookup_v     = pg[0];
  assign lookup_d     = pg[1];
  assign lookup_frame = pg[28:2];
  assign lookup_xi    = pg[29];
  assign lookup_ri    = pg[30];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_entryhi  <= '0;
      reg_entrylo0 <= '0;
      reg_entrylo1 <= '0;
      reg_pagemask <= '0;
      reg_index    <= '0;
      reg_mmid     <= '0;
      e_g          <= '0;
      e_inv        <= '1;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i]  <= '0;
        e_pm[i]   <= '0;
        e_asid[i] <= '0;
        e_mmid[i] <= '0;
        e_pg0[i]  <= '0;
        e_pg1[i]  <= '0;
      end
    end else if (cmd_read) begin
      if (e_inv[sel_idx]) begin
        reg_entryhi  <= INV_HI;
        reg_pagemask <= '0;
        reg_entrylo0 <= '0;
        reg_entrylo1 <= '0;
      end else begin
        reg_entryhi  <= {e_vpn[sel_idx], 3'b0, cfg_mmid_en ? '0 : e_asid[sel_idx]};
        reg_pagemask <= {3'b0, e_pm[sel_idx], 13'b0};
        reg_entrylo0 <= {e_pg0[sel_idx], e_g[sel_idx]};
        reg_entrylo1 <= {e_pg1[sel_idx], e_g[sel_idx]};
        reg_mmid     <= 32'(e_mmid[sel_idx]);
      end
    end else if (cmd_probe) begin
      reg_index <= (|hit_pr) ? 32'(pr_idx) : MISS_WORD;
    end else if (cmd_write) begin
      e_vpn[sel_idx]  <= reg_entryhi[31:13];
      e_inv[sel_idx]  <= reg_entryhi[10];
      e_asid[sel_idx] <= reg_entryhi[ID_W-1:0] & asid_mask;
      e_mmid[sel_idx] <= reg_mmid[MMID_W-1:0];
      e_pm[sel_idx]   <= reg_pagemask[28:13];
      e_g[sel_idx]    <= reg_entrylo0[0] & reg_entrylo1[0];
      e_pg0[sel_idx]  <= reg_entrylo0[31:1];
      e_pg1[sel_idx]  <= reg_entrylo1[31:1];
    end else if (reg_wr_en) begin
      case (reg_sel)
        3'd0:    reg_entryhi  <= reg_wdata;
        3'd1:    reg_entrylo0 <= reg_wdata;
        3'd2:    reg_entrylo1 <= reg_wdata;
        3'd3:    reg_pagemask <= {3'b0, reg_wdata[28:13], 13'b0};
        3'd4:    reg_index    <= reg_wdata;
        3'd5:    reg_mmid     <= reg_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_tagged_lookup_chk.sv
module tlb_tagged_lookup_chk #(
  parameter int ENTRIES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_mmid_en,
  input logic        cmd_probe,
  input logic        cmd_write,
  input logic        cmd_read,
  input logic        lookup_hit,
  input logic        lookup_odd,
  input logic        lookup_v,
  input logic [31:0] reg_entryhi,
  input logic [31:0] reg_index
);
  a_r10_probe_result: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_probe && !cmd_read |=>
      (reg_index[31] ? (reg_index[30:0] == '0) : (reg_index < 32'(ENTRIES))));

  a_r7_mmid_read_hides_id: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_read && cfg_mmid_en |=> reg_entryhi[9:0] == '0);

  a_r5_write_leaves_regs: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write && !cmd_read && !cmd_probe |=> $stable(reg_index) && $stable(reg_entryhi));

  a_r11_miss_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hit |-> !lookup_v && !lookup_odd);

  a_r1_reset_clears_index: assert property (@(posedge clk)
    !rst_n |=> reg_index == '0);
endmodule

bind tlb_tagged_lookup tlb_tagged_lookup_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mmid_en(cfg_mmid_en),
  .cmd_probe(cmd_probe), .cmd_write(cmd_write), .cmd_read(cmd_read),
  .lookup_hit(lookup_hit), .lookup_odd(lookup_odd), .lookup_v(lookup_v),
  .reg_entryhi(reg_entryhi), .reg_index(reg_index)
);

// File: tb/tlb_tagged_lookup_tb.sv
module tlb_tagged_lookup_tb_top;
  localparam int PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_mmid_en = 0, cfg_asid_ext = 1;
  logic reg_wr_en = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic cmd_probe = 0, cmd_write = 0, cmd_read = 0;
  logic [31:0] lookup_va = 0;
  logic lookup_hit, lookup_odd, lookup_v, lookup_d, lookup_ri, lookup_xi;
  logic [2:0] lookup_idx;
  logic [26:0] lookup_frame;
  logic [31:0] reg_entryhi, reg_entrylo0, reg_entrylo1, reg_pagemask, reg_index, reg_mmid;

  always #(PERIOD/2) clk = ~clk;

  tlb_tagged_lookup #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mmid_en(cfg_mmid_en), .cfg_asid_ext(cfg_asid_ext),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_probe(cmd_probe), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .lookup_va(lookup_va), .lookup_hit(lookup_hit), .lookup_idx(lookup_idx),
    .lookup_odd(lookup_odd), .lookup_v(lookup_v), .lookup_d(lookup_d),
    .lookup_ri(lookup_ri), .lookup_xi(lookup_xi), .lookup_frame(lookup_frame),
    .reg_entryhi(reg_entryhi), .reg_entrylo0(reg_entrylo0), .reg_entrylo1(reg_entrylo1),
    .reg_pagemask(reg_pagemask), .reg_index(reg_index), .reg_mmid(reg_mmid));

  int n_cmp = 0, n_bad = 0;
  logic [18:0] m_vpn [N];
  logic [15:0] m_pm [N];
  logic [9:0]  m_asid [N];
  logic [31:0] m_mmid [N], m_lo0 [N], m_lo1 [N];
  logic        m_g [N], m_inv [N];
  logic [31:0] mm_now;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setreg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
    if (sel == 3'd5) mm_now = d;
  endtask

  task automatic docmd(input int kind);
    @(negedge clk);
    cmd_read = (kind == 0); cmd_probe = (kind == 1); cmd_write = (kind == 2);
    @(negedge clk);
    cmd_read = 0; cmd_probe = 0; cmd_write = 0;
  endtask

  function automatic int first_hit(input logic [18:0] vpn, input logic mi, input logic [31:0] cur);
    logic [31:0] t;
    for (int i = 0; i < N; i++) begin
      t = mi ? m_mmid[i] : {22'b0, m_asid[i]};
      if (!m_inv[i] && (m_g[i] || t == cur) &&
          ((vpn | {3'b0, m_pm[i]}) == (m_vpn[i] | {3'b0, m_pm[i]})))
        return i;
    end
    return -1;
  endfunction

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ehi, lo0, lo1, cur, exp_hi, a;
    logic [35:0] exp_lk;
    int e;
    for (int i = 0; i < N; i++) m_inv[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 regs", {reg_entryhi, reg_index}, 64'd0);
    chk("R1 regs2", {reg_entrylo0, reg_entrylo1}, 64'd0);
    chk("R1 regs3", {reg_pagemask, reg_mmid}, 64'd0);
    lookup_va = 32'h0; #1;
    chk("R1 lookup", lookup_hit, 0);
    docmd(1);
    chk("R1 R10 probe", reg_index, 32'h8000_0000);
    // R13: register load port
    for (int s = 0; s < 6; s++) begin
      a = 32'hA5C3_0F69 ^ (32'h1111_1111 * s);
      setreg(3'(s), a);
      case (s)
        0: chk("R13 hi", reg_entryhi, a);
        1: chk("R13 lo0", reg_entrylo0, a);
        2: chk("R13 lo1", reg_entrylo1, a);
        3: chk("R13 pm", reg_pagemask, a & 32'h1FFF_E000);
        4: chk("R13 idx", reg_index, a);
        default: chk("R13 mmid", reg_mmid, a);
      endcase
    end
    // R5 R6: fill entries
    for (int i = 0; i < N; i++) begin
      cfg_mmid_en = 0;
      cfg_asid_ext = (i != 4);
      m_vpn[i] = 19'h100 + 19'(2 * i);
      m_pm[i] = (i == 2) ? 16'h3 : (i == 5) ? 16'hF : 16'h0;
      m_mmid[i] = 32'hC0DE_0000 + 32'(i) * 32'h0101_0011;
      ehi = {m_vpn[i], 2'b0, (i == 7), 10'h3A0 + 10'(i)};
      lo0 = {i[0], i[1], 27'(i * 1000 + 5), 1'b1, 1'b1, (i == 3) || (i == 6)};
      lo1 = {~i[0], i[2], 27'(i * 1000 + 7), 1'b0, (i != 1), (i == 3)};
      setreg(0, ehi); setreg(1, lo0); setreg(2, lo1);
      setreg(3, {3'b0, m_pm[i], 13'b0}); setreg(5, m_mmid[i]);
      setreg(4, 32'h8000_0000 | 32'(i + 16));
      docmd(2);
      chk("R5 index kept", reg_index, 32'h8000_0000 | 32'(i + 16));
      m_asid[i] = ehi[9:0] & (cfg_asid_ext ? 10'h3FF : 10'h0FF);
      m_g[i] = lo0[0] & lo1[0];
      m_inv[i] = ehi[10];
      m_lo0[i] = {lo0[31:1], m_g[i]};
      m_lo1[i] = {lo1[31:1], m_g[i]};
    end
    // R7 R8 R6 R4: read back in both tag modes
    cfg_asid_ext = 1;
    for (int mi = 0; mi < 2; mi++)
      for (int i = 0; i < N; i++) begin
        cfg_mmid_en = mi[0];
        setreg(4, 32'(i + N));
        docmd(0);
        if (m_inv[i]) begin
          chk("R8 hi", reg_entryhi, 32'h400);
          chk("R8 lo", {reg_entrylo0, reg_entrylo1}, 64'd0);
          chk("R8 pm/mmid", {reg_pagemask, reg_mmid}, {32'd0, mm_now});
        end else begin
          exp_hi = {m_vpn[i], 13'b0} | (mi ? 32'd0 : {22'b0, m_asid[i]});
          chk("R7 R4 hi", reg_entryhi, exp_hi);
          chk("R7 R5 lo", {reg_entrylo0, reg_entrylo1}, {m_lo0[i], m_lo1[i]});
          chk("R7 pm/mmid", {reg_pagemask, reg_mmid}, {3'b0, m_pm[i], 13'b0, m_mmid[i]});
          mm_now = m_mmid[i];
        end
      end
    // R2 R3 R4 R11 R12: lookup sweep
    for (int mi = 0; mi < 2; mi++)
      for (int ex = 0; ex < 2; ex++)
        for (int k = 0; k <= N; k++) begin
          cfg_mmid_en = mi[0]; cfg_asid_ext = ex[0];
          if (mi) begin
            setreg(5, (k < N) ? m_mmid[k] : 32'h1234_5678);
            cur = mm_now;
          end else begin
            setreg(0, {22'b0, 10'h3A0 + 10'(k)});
            cur = {22'b0, (10'h3A0 + 10'(k)) & (ex ? 10'h3FF : 10'h0FF)};
          end
          for (int v = 'hFC; v < 'h114; v++)
            for (int s = 0; s < 2; s++) begin
              @(negedge clk);
              lookup_va = {19'(v), 13'b0} | (s ? 32'h1000 : 32'h0);
              #1;
              e = first_hit(19'(v), mi[0], cur);
              if (e < 0) exp_lk = '0;
              else begin
                a = lookup_va[12 + $countones(m_pm[e])] ? m_lo1[e] : m_lo0[e];
                exp_lk = {1'b1, 3'(e), lookup_va[12 + $countones(m_pm[e])],
                          a[1], a[2], a[31], a[30], a[29:3]};
              end
              chk("R2 R3 R4 R11 R12 lookup",
                  {lookup_hit, lookup_idx, lookup_odd, lookup_v, lookup_d,
                   lookup_ri, lookup_xi, lookup_frame}, exp_lk);
            end
        end
    // R9 R10: probe sweep
    cfg_asid_ext = 1;
    for (int mi = 0; mi < 2; mi++)
      for (int k = 0; k <= N; k++) begin
        cfg_mmid_en = mi[0];
        if (mi) setreg(5, (k < N) ? m_mmid[k] : 32'h1234_5678);
        cur = mi ? mm_now : {22'b0, 10'h3A0 + 10'(k)};
        for (int v = 'hFC; v < 'h114; v++) begin
          setreg(0, {19'(v), 3'b0, 10'h3A0 + 10'(k)});
          docmd(1);
          e = first_hit(19'(v), mi[0], cur);
          chk(e < 0 ? "R10 probe miss" : "R9 probe hit", reg_index,
              e < 0 ? 32'h8000_0000 : 32'(e));
        end
      end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule